// File: doc/BRIEF.md
# Redundant Reference Clock Monitor and Selector

This block watches two reference clocks and a feedback clock, all sampled by one fast system clock. A reference is judged dead when it holds one level while the feedback clock keeps moving. Each reference has a sticky alarm flag. The block also chooses which reference drives the downstream loop. The user names a primary reference. When the reference in use fails and the other one is still healthy, the block moves to the other one. It does not move back by itself.

An active-low alarm-reset pin clears the flags and the switch decision. It is turned into a single internal pulse, so holding the pin low does not mask a fault that persists. A manual-override input pins the selection to the primary. While override is high the flags keep updating, but no automatic switch is made. An asynchronous master reset returns the block to its idle state. The selection is given out twice: as a level indicator, and as a zero-based index for an external clock mux.

Top module: `refclk_guard`

## Requirements
- R1: A reference that stays at one level, high or low, while 3 feedback edges pass sets its flag. Rising and falling feedback edges both count. After only 2 such edges the flag stays 0. Any transition of the reference restarts the count. `bad_flag[0]` belongs to `ref_in[0]` and `bad_flag[1]` belongs to `ref_in[1]`.
- R2: The flags are active high. A set flag stays 1 after its reference toggles again, until an alarm pulse arrives.
- R3: `alarm_rst_n` is active low. Its falling edge, after synchronization, makes one single-cycle pulse. The pulse clears both flags and both edge counts. While the pin stays low, a reference that is still stuck sets its flag again after 3 more feedback edges.
- R4: The alarm pulse ends any switch, so `sel_ind` returns to `prim_sel`. A value of 0 means reference 0 and 1 means reference 1.
- R5: With `man_ovr` low, the selection moves to the other reference when the flag of the selected reference is set and the flag of the other one is clear. `mux_idx` always equals `sel_ind`.
- R6: After a switch, the selection stays on the new reference even when the failed one starts toggling again.
- R7: While `man_ovr` is 1, `sel_ind` equals `prim_sel` and the flags still update. No switch decision is made during override. When override drops, the decision is made on the next clock.
- R8: When both flags are set, the selection is held. If both references fail in the same cycle, no switch happens.
- R9: A low `rst_n` clears both flags and any switch at once, without waiting for a clock edge, and `sel_ind` equals `prim_sel`.
- R10: With `man_ovr` low, `sel_ind` differs from `prim_sel` only while the flag of the primary is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples every other input |
| rst_n | input | 1 | Asynchronous master reset, active low |
| ref_in | input | 2 | The two reference clocks, oversampled |
| fb_in | input | 1 | Feedback clock; each of its edges is one unit of fault time |
| prim_sel | input | 1 | Primary reference choice: 0 = reference 0, 1 = reference 1 |
| man_ovr | input | 1 | Manual override: 1 pins the selection to the primary |
| alarm_rst_n | input | 1 | Alarm reset, active low, acts once on each falling edge |
| bad_flag | output | 2 | Sticky fault flags, one bit per reference |
| sel_ind | output | 1 | Selected-reference indicator |
| mux_idx | output | 1 | Zero-based index of the selected reference, for an external mux |

## Verification
The references are tested stuck high and stuck low, each with feedback edges counted one at a time. Checking the flag after the second and the third edge pins down the exact threshold. The primary and the secondary are each failed on their own, which shows a switch happens only when the failing reference is the one in use. Failing both references in sequence and then together separates "hold because both are bad" from a switch made in the wrong direction. Holding alarm reset low against a reference that stays stuck shows that the reset is edge-based. Releasing override over a failed primary shows that the switch decision was suspended, not lost.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int NUM_REF = 2;

  // Edge count after one more feedback edge, saturating at the limit.
  function automatic int sat_inc(input int cnt, input int lim);
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction

  // True once the count has reached the fault threshold.
  function automatic logic hit_limit(input int cnt, input int lim);
    return cnt >= lim;
  endfunction

  // Reference index to use, from primary choice, switch state and override.
  function automatic logic pick_ref(input logic prim, input logic sw, input logic ovr);
    return ovr ? prim : (prim ^ sw);
  endfunction
endpackage

// File: rtl/rcg_sync.sv
module rcg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic samp,
  output logic prev
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {(STAGES+1){RST_VAL}};
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign samp = sh[STAGES-1];
  assign prev = sh[STAGES];
endmodule

// File: rtl/rcg_stuck_mon.sv
module rcg_stuck_mon
  import rcg_pkg::*;
#(
  parameter int FAIL_EDGES = 3,
  parameter int CNT_W      = $clog2(FAIL_EDGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fb_edge,
  input  logic ref_chg,
  output logic bad
);
  logic [CNT_W-1:0] cnt;
  int               cnt_nxt;
  logic             hit;

  always_comb begin
    cnt_nxt = sat_inc(int'(cnt), FAIL_EDGES);
    hit     = fb_edge && !ref_chg && hit_limit(cnt_nxt, FAIL_EDGES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      bad <= 1'b0;
    end else begin
      if (ref_chg)      cnt <= '0;
      else if (fb_edge) cnt <= CNT_W'(cnt_nxt);
      if (hit)          bad <= 1'b1;
    end
  end
endmodule

// File: rtl/rcg_sel_ctrl.sv
module rcg_sel_ctrl
  import rcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       prim_sel,
  input  logic       man_ovr,
  input  logic [1:0] bad,
  output logic       sw_state,
  output logic       sel
);
  logic sw_q;
  logic take;
  logic eff_sw;

  assign eff_sw = sw_q & bad[prim_sel];
  assign take   = !man_ovr && !sw_q && bad[prim_sel] && !bad[!prim_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sw_q <= 1'b0;
    else if (clr)  sw_q <= 1'b0;
    else if (take) sw_q <= 1'b1;
    else           sw_q <= eff_sw;
  end

  assign sw_state = sw_q;
  assign sel      = pick_ref(prim_sel, eff_sw, man_ovr);
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
  import rcg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAIL_EDGES  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_in,
  input  logic       fb_in,
  input  logic       prim_sel,
  input  logic       man_ovr,
  input  logic       alarm_rst_n,
  output logic [1:0] bad_flag,
  output logic       sel_ind,
  output logic       mux_idx
);
  localparam int CNT_W = $clog2(FAIL_EDGES + 1);

  logic [NUM_REF-1:0] ref_samp, ref_prev, ref_chg;
  logic               fb_samp, fb_prev, fb_edge;
  logic               al_samp, al_prev, alarm_pulse;
  logic               sw_state;
  logic               sel_w;

  for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
    rcg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ref_in[i]),
      .samp(ref_samp[i]), .prev(ref_prev[i]));

    assign ref_chg[i] = ref_samp[i] ^ ref_prev[i];

    rcg_stuck_mon #(.FAIL_EDGES(FAIL_EDGES), .CNT_W(CNT_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .clr(alarm_pulse), .fb_edge(fb_edge),
      .ref_chg(ref_chg[i]), .bad(bad_flag[i]));
  end

  rcg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_fb_sync (
    .clk(clk), .rst_n(rst_n), .din(fb_in), .samp(fb_samp), .prev(fb_prev));
  assign fb_edge = fb_samp ^ fb_prev;

  rcg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_al_sync (
    .clk(clk), .rst_n(rst_n), .din(alarm_rst_n), .samp(al_samp), .prev(al_prev));
  assign alarm_pulse = al_prev & ~al_samp;

  rcg_sel_ctrl u_sel (
    .clk(clk), .rst_n(rst_n), .clr(alarm_pulse), .prim_sel(prim_sel),
    .man_ovr(man_ovr), .bad(bad_flag), .sw_state(sw_state), .sel(sel_w));

  assign sel_ind = sel_w;
  assign mux_idx = sel_w;
endmodule

// File: rtl/refclk_guard_chk.sv
module refclk_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prim_sel,
  input logic       man_ovr,
  input logic [1:0] bad_flag,
  input logic       sel_ind,
  input logic       mux_idx,
  input logic       fb_edge,
  input logic       alarm_pulse,
  input logic       sw_state
);
  AST_FLAG0_NEEDS_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_flag[0]) |-> $past(fb_edge)); // R1
  AST_FLAG1_NEEDS_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_flag[1]) |-> $past(fb_edge)); // R1
  AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_flag[0] && !alarm_pulse) |=> bad_flag[0]); // R2
  AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_flag[1] && !alarm_pulse) |=> bad_flag[1]); // R2
  AST_ALARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> (bad_flag == 2'b00)); // R3
  AST_ALARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> !alarm_pulse); // R3
  AST_ALARM_UNSWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> !sw_state); // R4
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mux_idx == sel_ind); // R5
  AST_OVR_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    man_ovr |-> (sel_ind == prim_sel)); // R7
  AST_BOTH_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((&bad_flag) && !alarm_pulse) |=> (sw_state == $past(sw_state))); // R8
  AST_DIFF_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_ovr && (sel_ind != prim_sel)) |-> bad_flag[prim_sel]); // R10
endmodule

bind refclk_guard refclk_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prim_sel(prim_sel), .man_ovr(man_ovr),
  .bad_flag(bad_flag), .sel_ind(sel_ind), .mux_idx(mux_idx),
  .fb_edge(fb_edge), .alarm_pulse(alarm_pulse), .sw_state(sw_state));

// File: tb/refclk_guard_tb.sv
`timescale 1ns/1ps
module refclk_guard_tb;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_in = 2'b00;
  logic       fb_in = 1'b0;
  logic       prim_sel = 1'b0;
  logic       man_ovr = 1'b0;
  logic       alarm_rst_n = 1'b1;
  logic [1:0] bad_flag;
  logic       sel_ind, mux_idx;

  logic [1:0] run = 2'b00;
  logic [1:0] hold = 2'b00;
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  refclk_guard u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .prim_sel(prim_sel), .man_ovr(man_ovr), .alarm_rst_n(alarm_rst_n),
    .bad_flag(bad_flag), .sel_ind(sel_ind), .mux_idx(mux_idx));

  always #(CLK_P/2) clk = ~clk;

  // Reference generators: ref 0 toggles every 2 cycles, ref 1 every 3.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (run[0]) begin if (cyc % 2 == 0) ref_in[0] <= ~ref_in[0]; end
    else ref_in[0] <= hold[0];
    if (run[1]) begin if (cyc % 3 == 0) ref_in[1] <= ~ref_in[1]; end
    else ref_in[1] <= hold[1];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fb_edges(input int n);
    for (int k = 0; k < n; k++) begin
      fb_in = ~fb_in;
      idle(8);
    end
  endtask

  task automatic stop_ref(input int i, input logic lvl);
    hold[i] = lvl;
    run[i]  = 1'b0;
    idle(6);
  endtask

  task automatic pulse_alarm();
    alarm_rst_n = 1'b0;
    idle(6);
    alarm_rst_n = 1'b1;
    idle(6);
  endtask

  task automatic t_reset();
    idle(3);
    chk("R9 flags in reset", bad_flag, 0);
    chk("R9 sel in reset", sel_ind, 0);
    rst_n = 1'b1;
    run = 2'b11;
    idle(10);
    chk("R9 flags after reset", bad_flag, 0);
    chk("R5 idx after reset", mux_idx, 0);
  endtask

  task automatic t_healthy();
    fb_edges(10);
    chk("R1 healthy no flag", bad_flag, 0);
    chk("R10 healthy sel", sel_ind, prim_sel);
  endtask

  task automatic t_stuck_secondary_high();
    stop_ref(1, 1'b1);
    fb_edges(2);
    chk("R1 high after 2 edges", bad_flag, 0);
    fb_edges(1);
    chk("R1 high after 3 edges", bad_flag, 2);
    chk("R5 no switch on secondary", sel_ind, 0);
    run[1] = 1'b1;
    fb_edges(3);
    chk("R2 sticky after recovery", bad_flag, 2);
    pulse_alarm();
    chk("R3 alarm clears", bad_flag, 0);
  endtask

  task automatic t_stuck_primary_low();
    stop_ref(0, 1'b0);
    fb_edges(2);
    chk("R1 low after 2 edges", bad_flag, 0);
    fb_edges(1);
    chk("R1 low after 3 edges", bad_flag, 1);
    chk("R5 switched sel", sel_ind, 1);
    chk("R5 switched idx", mux_idx, 1);
    run[0] = 1'b1;
    fb_edges(4);
    chk("R6 no switch back", sel_ind, 1);
    chk("R2 flag kept", bad_flag, 1);
    pulse_alarm();
    chk("R4 back to primary", sel_ind, 0);
    chk("R4 flags cleared", bad_flag, 0);
  endtask

  task automatic t_alarm_hold();
    stop_ref(1, 1'b0);
    fb_edges(3);
    chk("R1 flag before hold", bad_flag, 2);
    alarm_rst_n = 1'b0;
    idle(6);
    chk("R3 cleared while low", bad_flag, 0);
    fb_edges(2);
    chk("R3 not yet re-set", bad_flag, 0);
    fb_edges(1);
    chk("R3 re-set while held low", bad_flag, 2);
    run[1] = 1'b1;
    alarm_rst_n = 1'b1;
    idle(6);
    chk("R3 release makes no pulse", bad_flag, 2);
    pulse_alarm();
    chk("R3 cleared again", bad_flag, 0);
  endtask

  task automatic t_override();
    man_ovr = 1'b1;
    stop_ref(0, 1'b1);
    fb_edges(3);
    chk("R7 flag updates in override", bad_flag, 1);
    chk("R7 sel pinned", sel_ind, 0);
    man_ovr = 1'b0;
    idle(3);
    chk("R7 switch after release", sel_ind, 1);
    run[0] = 1'b1;
    pulse_alarm();
    chk("R4 sel after override case", sel_ind, 0);
  endtask

  task automatic t_double();
    stop_ref(0, 1'b0);
    fb_edges(3);
    chk("R5 first failure switch", sel_ind, 1);
    stop_ref(1, 1'b1);
    fb_edges(3);
    chk("R8 both flags", bad_flag, 3);
    chk("R8 sel held", sel_ind, 1);
    pulse_alarm();
    chk("R4 sel after alarm", sel_ind, 0);
    fb_edges(3);
    chk("R8 simultaneous flags", bad_flag, 3);
    chk("R8 simultaneous no switch", sel_ind, 0);
    run = 2'b11;
    pulse_alarm();
    chk("R3 double cleared", bad_flag, 0);
  endtask

  task automatic t_prim1();
    prim_sel = 1'b1;
    idle(2);
    chk("R10 prim 1 sel", sel_ind, 1);
    stop_ref(1, 1'b1);
    fb_edges(3);
    chk("R5 switch to ref0", mux_idx, 0);
    chk("R10 differs with primary bad", bad_flag[1], 1);
    run[1] = 1'b1;
    fb_edges(3);
    chk("R6 stays on ref0", sel_ind, 0);
    pulse_alarm();
    chk("R4 back to ref1", sel_ind, 1);
    stop_ref(0, 1'b0);
    fb_edges(3);
    chk("R5 secondary fail no switch", sel_ind, 1);
    #(CLK_P/4);
    rst_n = 1'b0;
    #1;
    chk("R9 async clear flags", bad_flag, 0);
    chk("R9 async sel", sel_ind, 1);
    idle(2);
    rst_n = 1'b1;
    run = 2'b11;
    idle(4);
  endtask

  initial begin
    t_reset();
    t_healthy();
    t_stuck_secondary_high();
    t_stuck_primary_low();
    t_alarm_hold();
    t_override();
    t_double();
    t_prim1();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule